// File: doc/BRIEF.md
# Bus Memory and I/O Cycle Sequencer

This block turns single requests from a CPU-side port into memory or I/O cycles on an 8/16-bit expansion bus with a 24-bit address. A request carries an address, write data, a read/write flag, a memory/IO flag and two byte enables. The block latches the address onto the bus and pulses the address latch enable. It then asserts one of four command strobes for a counted number of wait units and steers the bytes onto the right data lanes. At the end it returns read data with a single-cycle done pulse.

Two address windows are decoded for memory cycles: a boot ROM window and a DOS ROM window. Each has its own chip select. Each window can run slow cycles or fast cycles. Slow cycles are paced by a bus-clock enable derived from the CPU clock. Fast cycles are paced by the CPU clock itself and skip the address latch pulse. The transfer width is chosen per half-cycle. The sequencer samples an active-low 16-bit acknowledge input, or takes a configuration bit that forces DOS-window accesses to 16 bits. Word requests to an 8-bit target are split into two byte cycles. An active-low zero-wait-state input shortens slow commands. A low-megabyte flag marks memory cycles below 1 MB.

Top module: `isa_cycle_seq`

## Requirements
- R1: During a command exactly one strobe is low: memr_n for memory read, memw_n for memory write, ior_n for I/O read, iow_n for I/O write; all four are high otherwise.
- R2: romcs_n is low during the command of a memory cycle whose address has bits 23:20 equal to 4'hF. doscs_n is low during the command of a memory cycle whose address has bits 23:17 equal to 7'b0000111. I/O cycles and other addresses select neither.
- R3: With cfg_rom_cmdqual (or cfg_dos_cmdqual) set to 1, that chip select is low only while a command strobe is low. With it set to 0, the chip select also covers the address phase and the hold clock around the command.
- R4: A slow half-cycle holds ale high for BUS_DIV clocks before the command. It holds the command low for W8_UNITS×BUS_DIV clocks when 8-bit and W16_UNITS×BUS_DIV clocks when 16-bit. I/O cycles, memory outside the windows, and windows whose fast bit is 0 are slow.
- R5: A fast half-cycle (ROM window with cfg_rom_fast=1, DOS window with cfg_dos_fast=1) never raises ale and holds the command low for FAST_CLKS clocks.
- R6: A half-cycle is 16-bit when ack16_n is low on the last clock of its address phase, otherwise 8-bit.
- R7: With cfg_dos_force16=1, every DOS-window access is 16-bit regardless of ack16_n. There is no such override for the ROM window.
- R8: On a slow cycle, zws_n low on the first wait unit of the command ends the command after one unit (BUS_DIV clocks). Fast cycles ignore zws_n.
- R9: An 8-bit request with req_be=2'b11 runs as two byte cycles: the first with sa[0]=0, the second with sa[0]=1. An 8-bit cycle at an odd address carries its byte on sd[7:0].
- R10: During a write command sd_oe=1. A 16-bit cycle drives the whole word. An 8-bit cycle drives req_wdata[7:0] on the low lane when sa[0]=0 and req_wdata[15:8] when sa[0]=1. During reads sd_oe=0.
- R11: At done, rdata[7:0] holds the low byte read when req_be[0]=1 and rdata[15:8] the high byte when req_be[1]=1. Unrequested bytes read 0. req_addr[0] is 1 only when req_be=2'b10.
- R12: lowmeg is 1 during a memory cycle whose address bits 23:20 are all zero, and 0 for I/O cycles and higher addresses.
- R13: sa keeps its value through the command and the clock after it. sbhe_n is low when the current transfer includes the high byte (req_be[1]=1, or the second half of a split).
- R14: done is high for exactly one clock per request. After reset all strobes and chip selects are high and ale, sd_oe and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rom_fast | input | 1 | ROM window runs fast cycles |
| cfg_dos_fast | input | 1 | DOS window runs fast cycles |
| cfg_dos_force16 | input | 1 | DOS-window accesses always 16-bit |
| cfg_rom_cmdqual | input | 1 | ROM chip select qualified by the command |
| cfg_dos_cmdqual | input | 1 | DOS chip select qualified by the command |
| req_valid | input | 1 | Request present (sampled when idle) |
| req_addr | input | 24 | Request byte address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with done |
| sa | output | 24 | Latched bus address |
| sbhe_n | output | 1 | High byte enable, active low |
| sd_out | output | 16 | Data bus drive value |
| sd_oe | output | 1 | Data bus drive enable |
| sd_in | input | 16 | Data bus receive value |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| ale | output | 1 | Address latch enable |
| romcs_n | output | 1 | ROM window chip select |
| doscs_n | output | 1 | DOS window chip select |
| lowmeg | output | 1 | Memory cycle below 1 MB |
| ack16_n | input | 1 | Target accepts 16-bit transfer, active low |
| zws_n | input | 1 | Zero-wait-state request, active low |

## Verification
The bench builds the sequencer with BUS_DIV=2, W8_UNITS=3, W16_UNITS=1 and FAST_CLKS=2. At these values a transaction lasts only about a dozen clocks, so the sweep covers every combination of the four speed/width/qualification settings, five address classes, direction, acknowledge, zero-wait and three byte-enable patterns. With W8_UNITS=3 the zero-wait shortening is visible as a different command length. With BUS_DIV=2 slow and fast timings differ in both ale length and command length. The memory address class at exactly 0x100000 puts the low-megabyte boundary in reach.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_HOLD,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_ROM,
    WIN_DOS
  } win_t;

endpackage

// File: rtl/isa_seq_tick.sv
// Bus-clock enable: one pulse every DIV CPU clocks while run is high,
// phase restarted whenever run drops.
module isa_seq_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run || cnt_q == LAST) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/isa_seq_decode.sv
// Window decode for memory cycles: a base address compared under a mask of
// the top TAG_BITS address bits.
module isa_seq_decode
  import isa_seq_pkg::*;
#(
  parameter logic [23:0] ROM_BASE     = 24'hF00000,
  parameter int          ROM_TAG_BITS = 4,
  parameter logic [23:0] DOS_BASE     = 24'h0E0000,
  parameter int          DOS_TAG_BITS = 7
) (
  input  logic [23:0] addr,
  input  logic        is_io,
  output win_t        win
);
  localparam logic [23:0] ROM_MASK = ~((24'h1 << (24 - ROM_TAG_BITS)) - 24'h1);
  localparam logic [23:0] DOS_MASK = ~((24'h1 << (24 - DOS_TAG_BITS)) - 24'h1);

  logic rom_hit, dos_hit;

  assign rom_hit = ((addr ^ ROM_BASE) & ROM_MASK) == 24'h0;
  assign dos_hit = ((addr ^ DOS_BASE) & DOS_MASK) == 24'h0;

  always_comb begin
    if (is_io)        win = WIN_NONE;
    else if (rom_hit) win = WIN_ROM;
    else if (dos_hit) win = WIN_DOS;
    else              win = WIN_NONE;
  end
endmodule

// File: rtl/isa_seq_lanes.sv
// Byte-lane steering for the outgoing word and assembly of read data.
module isa_seq_lanes (
  input  logic [15:0] wdata,
  input  logic        sa0,
  input  logic        wide,
  input  logic [1:0]  be,
  input  logic [15:0] sd_in,
  input  logic [15:0] rdata_q,
  output logic [15:0] sd_out,
  output logic [15:0] rdata_cap
);
  always_comb begin
    if (wide)     sd_out = wdata;
    else if (sa0) sd_out = {wdata[15:8], wdata[15:8]};
    else          sd_out = wdata;
  end

  always_comb begin
    if (wide) begin
      rdata_cap[15:8] = be[1] ? sd_in[15:8] : rdata_q[15:8];
      rdata_cap[7:0]  = be[0] ? sd_in[7:0]  : rdata_q[7:0];
    end else if (sa0) begin
      rdata_cap = {sd_in[7:0], rdata_q[7:0]};
    end else begin
      rdata_cap = {rdata_q[15:8], sd_in[7:0]};
    end
  end
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_seq_pkg::*;
#(
  parameter int          BUS_DIV      = 4,
  parameter int          W8_UNITS     = 4,
  parameter int          W16_UNITS    = 1,
  parameter int          FAST_CLKS    = 2,
  parameter logic [23:0] ROM_BASE     = 24'hF00000,
  parameter int          ROM_TAG_BITS = 4,
  parameter logic [23:0] DOS_BASE     = 24'h0E0000,
  parameter int          DOS_TAG_BITS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_rom_fast,
  input  logic        cfg_dos_fast,
  input  logic        cfg_dos_force16,
  input  logic        cfg_rom_cmdqual,
  input  logic        cfg_dos_cmdqual,
  input  logic        req_valid,
  input  logic [23:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic        req_write,
  input  logic        req_io,
  input  logic [1:0]  req_be,
  output logic        done,
  output logic [15:0] rdata,
  output logic [23:0] sa,
  output logic        sbhe_n,
  output logic [15:0] sd_out,
  output logic        sd_oe,
  input  logic [15:0] sd_in,
  output logic        memr_n,
  output logic        memw_n,
  output logic        ior_n,
  output logic        iow_n,
  output logic        ale,
  output logic        romcs_n,
  output logic        doscs_n,
  output logic        lowmeg,
  input  logic        ack16_n,
  input  logic        zws_n
);
  localparam int WMAX_A = (W8_UNITS > W16_UNITS) ? W8_UNITS : W16_UNITS;
  localparam int WMAX   = (WMAX_A > FAST_CLKS) ? WMAX_A : FAST_CLKS;
  localparam int CW     = (WMAX > 1) ? $clog2(WMAX) : 1;
  localparam logic [CW-1:0] LIM_W8   = CW'(W8_UNITS - 1);
  localparam logic [CW-1:0] LIM_W16  = CW'(W16_UNITS - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(FAST_CLKS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  seq_state_t    st_q, st_d;
  logic [23:0]   addr_q, addr_d;
  logic [15:0]   wdata_q, wdata_d;
  logic          write_q, write_d;
  logic          io_q, io_d;
  logic [1:0]    be_q, be_d;
  win_t          win_q, win_d;
  logic          fast_q, fast_d;
  logic          wide_q, wide_d;
  logic          second_q, second_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic [15:0]   rdata_q, rdata_d;

  win_t          req_win;
  logic          tick, unit, zws_hit;
  logic [CW-1:0] lim;
  logic [15:0]   rdata_cap;
  logic          cmd_on, busy;

  isa_seq_decode #(
    .ROM_BASE     (ROM_BASE),
    .ROM_TAG_BITS (ROM_TAG_BITS),
    .DOS_BASE     (DOS_BASE),
    .DOS_TAG_BITS (DOS_TAG_BITS)
  ) u_dec (
    .addr  (req_addr),
    .is_io (req_io),
    .win   (req_win)
  );

  isa_seq_tick #(.DIV(BUS_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (!fast_q && (st_q == ST_ADDR || st_q == ST_CMD)),
    .tick  (tick)
  );

  isa_seq_lanes u_lanes (
    .wdata     (wdata_q),
    .sa0       (sa[0]),
    .wide      (wide_q),
    .be        (be_q),
    .sd_in     (sd_in),
    .rdata_q   (rdata_q),
    .sd_out    (sd_out),
    .rdata_cap (rdata_cap)
  );

  assign unit    = fast_q ? 1'b1 : tick;
  assign lim     = fast_q ? LIM_FAST : (wide_q ? LIM_W16 : LIM_W8);
  assign zws_hit = !fast_q && (wcnt_q == '0) && !zws_n;

  // next-state
  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    write_d  = write_q;
    io_d     = io_q;
    be_d     = be_q;
    win_d    = win_q;
    fast_d   = fast_q;
    wide_d   = wide_q;
    second_d = second_q;
    wcnt_d   = wcnt_q;
    rdata_d  = rdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d     = ST_ADDR;
          addr_d   = req_addr;
          wdata_d  = req_wdata;
          write_d  = req_write;
          io_d     = req_io;
          be_d     = req_be;
          win_d    = req_win;
          fast_d   = (req_win == WIN_ROM && cfg_rom_fast) ||
                     (req_win == WIN_DOS && cfg_dos_fast);
          second_d = 1'b0;
          rdata_d  = '0;
        end
      end
      ST_ADDR: begin
        if (unit) begin
          wide_d = !second_q &&
                   ((win_q == WIN_DOS && cfg_dos_force16) || !ack16_n);
          wcnt_d = '0;
          st_d   = ST_CMD;
        end
      end
      ST_CMD: begin
        if (unit) begin
          if (zws_hit || wcnt_q == lim) begin
            st_d = ST_HOLD;
            if (!write_q) rdata_d = rdata_cap;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (!wide_q && be_q == 2'b11 && !second_q) begin
          second_d = 1'b1;
          st_d     = ST_ADDR;
        end else begin
          st_d = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      write_q  <= 1'b0;
      io_q     <= 1'b0;
      be_q     <= '0;
      win_q    <= WIN_NONE;
      fast_q   <= 1'b0;
      wide_q   <= 1'b0;
      second_q <= 1'b0;
      wcnt_q   <= '0;
      rdata_q  <= '0;
    end else begin
      st_q     <= st_d;
      addr_q   <= addr_d;
      wdata_q  <= wdata_d;
      write_q  <= write_d;
      io_q     <= io_d;
      be_q     <= be_d;
      win_q    <= win_d;
      fast_q   <= fast_d;
      wide_q   <= wide_d;
      second_q <= second_d;
      wcnt_q   <= wcnt_d;
      rdata_q  <= rdata_d;
    end
  end

  // outputs
  assign cmd_on = (st_q == ST_CMD);
  assign busy   = (st_q == ST_ADDR) || (st_q == ST_CMD) || (st_q == ST_HOLD);

  assign memr_n  = !(cmd_on && !io_q && !write_q);
  assign memw_n  = !(cmd_on && !io_q &&  write_q);
  assign ior_n   = !(cmd_on &&  io_q && !write_q);
  assign iow_n   = !(cmd_on &&  io_q &&  write_q);
  assign ale     = (st_q == ST_ADDR) && !fast_q;
  assign romcs_n = !(win_q == WIN_ROM && (cfg_rom_cmdqual ? cmd_on : busy));
  assign doscs_n = !(win_q == WIN_DOS && (cfg_dos_cmdqual ? cmd_on : busy));
  assign lowmeg  = busy && !io_q && (addr_q[23:20] == 4'h0);
  assign sa      = {addr_q[23:1], addr_q[0] | second_q};
  assign sbhe_n  = !(second_q || be_q[1]);
  assign sd_oe   = cmd_on && write_q;
  assign done    = (st_q == ST_DONE);
  assign rdata   = rdata_q;
endmodule

// File: rtl/isa_cycle_seq_chk.sv
module isa_cycle_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        memr_n,
  input logic        memw_n,
  input logic        ior_n,
  input logic        iow_n,
  input logic        ale,
  input logic [23:0] sa,
  input logic        sd_oe,
  input logic        lowmeg,
  input logic        romcs_n,
  input logic        doscs_n,
  input logic        cfg_rom_cmdqual,
  input logic        cfg_dos_cmdqual,
  input logic        done
);
  logic cmd_idle;
  assign cmd_idle = memr_n && memw_n && ior_n && iow_n;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~memr_n, ~memw_n, ~ior_n, ~iow_n}) <= 1); // R1

  AST_QUAL_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rom_cmdqual && !romcs_n) |-> !cmd_idle); // R3

  AST_QUAL_DOS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dos_cmdqual && !doscs_n) |-> !cmd_idle); // R3

  AST_ALE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> cmd_idle); // R4

  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!memw_n || !iow_n) |-> sd_oe); // R10

  AST_LOWMEG_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    lowmeg |-> (sa[23:20] == 4'h0)); // R12

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_idle) |-> $stable(sa)); // R13

  AST_ADDR_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_idle && $past(!cmd_idle)) |-> $stable(sa)); // R13

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R14
endmodule

bind isa_cycle_seq isa_cycle_seq_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .memr_n          (memr_n),
  .memw_n          (memw_n),
  .ior_n           (ior_n),
  .iow_n           (iow_n),
  .ale             (ale),
  .sa              (sa),
  .sd_oe           (sd_oe),
  .lowmeg          (lowmeg),
  .romcs_n         (romcs_n),
  .doscs_n         (doscs_n),
  .cfg_rom_cmdqual (cfg_rom_cmdqual),
  .cfg_dos_cmdqual (cfg_dos_cmdqual),
  .done            (done)
);

// File: tb/isa_cycle_seq_test.sv
`timescale 1ns/1ps
module isa_cycle_seq_test;
  localparam int DIV  = 2;
  localparam int W8   = 3;
  localparam int W16  = 1;
  localparam int FAST = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_rom_fast, cfg_dos_fast, cfg_dos_force16;
  logic        cfg_rom_cmdqual, cfg_dos_cmdqual;
  logic        req_valid;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_write, req_io;
  logic [1:0]  req_be;
  logic        done;
  logic [15:0] rdata;
  logic [23:0] sa;
  logic        sbhe_n;
  logic [15:0] sd_out;
  logic        sd_oe;
  logic [15:0] sd_in;
  logic        memr_n, memw_n, ior_n, iow_n, ale, romcs_n, doscs_n, lowmeg;
  logic        ack16_n, zws_n;
  logic [15:0] dev_d;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  // target model: high byte on the high lane, odd byte mirrored onto the low lane
  assign sd_in = {dev_d[15:8], sa[0] ? dev_d[15:8] : dev_d[7:0]};

  isa_cycle_seq #(
    .BUS_DIV(DIV), .W8_UNITS(W8), .W16_UNITS(W16), .FAST_CLKS(FAST)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rom_fast(cfg_rom_fast), .cfg_dos_fast(cfg_dos_fast),
    .cfg_dos_force16(cfg_dos_force16),
    .cfg_rom_cmdqual(cfg_rom_cmdqual), .cfg_dos_cmdqual(cfg_dos_cmdqual),
    .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_io(req_io), .req_be(req_be),
    .done(done), .rdata(rdata), .sa(sa), .sbhe_n(sbhe_n),
    .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .ale(ale), .romcs_n(romcs_n), .doscs_n(doscs_n), .lowmeg(lowmeg),
    .ack16_n(ack16_n), .zws_n(zws_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_tx(input int cfg, input int win, input bit wr, input bit ack,
                        input bit zws, input int bsel, input int idx);
    logic [1:0]  be;
    logic [23:0] base, addr;
    logic [15:0] w, d, exp_rd;
    logic [3:0]  exp_strb;
    logic [23:0] prev_sa;
    bit is_io, in_rom, in_dos, fast, wide, exp_low, prev_cmd, got_done;
    int halves, per, exp_cmd, exp_ale, n_cmd, n_ale, n_cs_idle, half;

    be = (bsel == 0) ? 2'b01 : (bsel == 1) ? 2'b10 : 2'b11;
    case (win)
      0:       base = 24'hF12340;
      1:       base = 24'h0E2340;
      2:       base = 24'h052340;
      3:       base = 24'h100000;
      default: base = 24'h000300;
    endcase
    addr   = base | {23'h0, be == 2'b10};
    w      = 16'(idx * 613 + 16'h1234);
    d      = 16'(idx * 947) ^ 16'hC3A5;
    is_io  = (win == 4);
    in_rom = (win == 0);
    in_dos = (win == 1);
    fast   = (in_rom && cfg[0]) || (in_dos && cfg[1]);
    wide   = (in_dos && cfg[2]) || ack;
    halves = (!wide && be == 2'b11) ? 2 : 1;
    per    = fast ? FAST : ((zws ? 1 : (wide ? W16 : W8)) * DIV);
    exp_cmd = halves * per;
    exp_ale = fast ? 0 : halves * DIV;
    exp_low = !is_io && (addr[23:20] == 4'h0);
    exp_rd  = {be[1] ? d[15:8] : 8'h00, be[0] ? d[7:0] : 8'h00};
    exp_strb = 4'b1111;   // {memr_n, memw_n, ior_n, iow_n}
    if (!is_io && !wr) exp_strb[3] = 1'b0;
    if (!is_io &&  wr) exp_strb[2] = 1'b0;
    if ( is_io && !wr) exp_strb[1] = 1'b0;
    if ( is_io &&  wr) exp_strb[0] = 1'b0;

    cfg_rom_fast    = cfg[0];
    cfg_dos_fast    = cfg[1];
    cfg_dos_force16 = cfg[2];
    cfg_rom_cmdqual = cfg[3];
    cfg_dos_cmdqual = cfg[3];
    req_addr  = addr;
    req_wdata = w;
    req_write = wr;
    req_io    = is_io;
    req_be    = be;
    ack16_n   = !ack;
    zws_n     = !zws;
    dev_d     = d;
    req_valid = 1'b1;

    n_cmd = 0; n_ale = 0; n_cs_idle = 0; half = 0;
    prev_cmd = 1'b0; prev_sa = '0; got_done = 1'b0;
    for (int t = 0; t < 300; t++) begin
      bit cmd_low;
      @(negedge clk);
      cmd_low = !memr_n || !memw_n || !ior_n || !iow_n;
      if (ale) n_ale++;
      if (prev_cmd && !cmd_low)
        check(sa == prev_sa, "R13 address after command", int'(sa), int'(prev_sa));
      if (cmd_low) begin
        if (!prev_cmd) half++;
        n_cmd++;
        check({memr_n, memw_n, ior_n, iow_n} == exp_strb, "R1 strobe select",
              int'({memr_n, memw_n, ior_n, iow_n}), int'(exp_strb));
        check(romcs_n == !in_rom && doscs_n == !in_dos, "R2 window select",
              int'({romcs_n, doscs_n}), int'({!in_rom, !in_dos}));
        check(lowmeg == exp_low, "R12 low megabyte", int'(lowmeg), int'(exp_low));
        check(sa[23:1] == addr[23:1], "R13 address bits", int'(sa), int'(addr));
        if (half == 2)
          check(sa[0] == 1'b1, "R9 second half odd", int'(sa[0]), 1);
        else
          check(sa[0] == addr[0], "R13 sa0 first half", int'(sa[0]), int'(addr[0]));
        check(sbhe_n == !(half == 2 || be[1]), "R13 sbhe_n", int'(sbhe_n),
              int'(!(half == 2 || be[1])));
        check(sd_oe == wr, "R10 drive enable", int'(sd_oe), int'(wr));
        if (wr) begin
          if (wide)
            check(sd_out == w, "R10 word lanes", int'(sd_out), int'(w));
          else
            check(sd_out[7:0] == (sa[0] ? w[15:8] : w[7:0]), "R10 R9 byte lane",
                  int'(sd_out[7:0]), int'(sa[0] ? w[15:8] : w[7:0]));
        end
        prev_sa = sa;
      end else if (!romcs_n || !doscs_n) begin
        n_cs_idle++;
      end
      prev_cmd = cmd_low;
      if (done) begin
        got_done = 1'b1;
        req_valid = 1'b0;
        break;
      end
    end
    req_valid = 1'b0;
    check(got_done, "R14 done seen", int'(got_done), 1);
    if (fast)
      check(n_ale == 0 && n_cmd == exp_cmd, "R5 fast timing",
            n_ale * 256 + n_cmd, exp_ale * 256 + exp_cmd);
    else if (zws)
      check(n_ale == exp_ale && n_cmd == exp_cmd, "R8 R4 zero wait timing",
            n_ale * 256 + n_cmd, exp_ale * 256 + exp_cmd);
    else
      check(n_ale == exp_ale && n_cmd == exp_cmd, "R4 slow timing",
            n_ale * 256 + n_cmd, exp_ale * 256 + exp_cmd);
    if (in_dos && cfg[2])
      check(half == halves, "R7 forced width halves", half, halves);
    else
      check(half == halves, "R6 R9 width halves", half, halves);
    check((n_cs_idle > 0) == ((in_rom || in_dos) && !cfg[3]), "R3 select outside command",
          n_cs_idle, int'((in_rom || in_dos) && !cfg[3]));
    if (!wr) check(rdata == exp_rd, "R11 read data", int'(rdata), int'(exp_rd));
    @(negedge clk);
    check(!done, "R14 done single clock", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_rom_fast = 0; cfg_dos_fast = 0; cfg_dos_force16 = 0;
    cfg_rom_cmdqual = 0; cfg_dos_cmdqual = 0;
    req_valid = 0; req_addr = '0; req_wdata = '0; req_write = 0; req_io = 0;
    req_be = 2'b01; ack16_n = 1; zws_n = 1; dev_d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R14 reset state
    check({memr_n, memw_n, ior_n, iow_n, romcs_n, doscs_n} == 6'b111111,
          "R14 idle strobes", int'({memr_n, memw_n, ior_n, iow_n, romcs_n, doscs_n}), 'h3f);
    check({ale, sd_oe, done} == 3'b000, "R14 idle ale oe done",
          int'({ale, sd_oe, done}), 0);

    begin
      int idx = 0;
      for (int cfg = 0; cfg < 16; cfg++)
        for (int win = 0; win < 5; win++)
          for (int wr = 0; wr < 2; wr++)
            for (int ack = 0; ack < 2; ack++)
              for (int zws = 0; zws < 2; zws++)
                for (int bsel = 0; bsel < 3; bsel++) begin
                  run_tx(cfg, win, wr[0], ack[0], zws[0], bsel, idx);
                  idx++;
                end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule